// File: doc/BRIEF.md
# UART Interrupt Status and Enable Unit

This unit gathers fourteen single-cycle event pulses coming from the transmit, receive, modem-line and bus logic of a UART. It records them in a sticky status register and masks them with an enable register of the same layout. It produces one active-high interrupt level. Two group lines are also brought out: one for enabled receive-side events and one for enabled transmit-side events, so that a handler can tell at a glance which path needs service.

Software clears status by writing ones to the bits it has handled. Bits written with zero are untouched. A status bit records its event whether or not it is enabled, so polling software can see masked events. An event that arrives in the same cycle as the clear of its bit wins, so no event is ever lost.

The asynchronous active-low reset clears both registers at once. Its release is synchronised through a two-stage chain.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While `arst_n` is low, the status and enable registers read zero and all interrupt outputs are low. After `arst_n` rises, both registers stay cleared through the next two rising clock edges, and writes or events are first taken at the third edge.
- R2: A pulse on `evt_i[k]` sets `stat_o[k]` from the next clock edge on, whatever `en_o[k]` holds. The bit positions are fixed as follows:
  - 0: transmit holding register empty
  - 1: receive holding register full
  - 2: transmit FIFO nearly empty
  - 3: transmit FIFO empty
  - 4: receive FIFO nearly full
  - 5: receive FIFO full
  - 6: transmit underrun
  - 7: receive overrun
  - 8: parity error
  - 9: framing error
  - 10: clear-to-send changed
  - 11: receive idle timeout
  - 12: break finished
  - 13: bad read of an empty receive FIFO
- R3: A set status bit stays set on every following edge until it is cleared by R4.
- R4: A cycle with `stat_wr_i` high clears each status bit whose `wdata_i` bit is 1 and leaves each bit whose `wdata_i` bit is 0 unchanged.
- R5: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit is set after the edge.
- R6: A cycle with `en_wr_i` high loads `wdata_i` into the enable register, readable on `en_o` from the next edge. Without the strobe the enable register holds its value.
- R7: `irq_o` is high exactly when some bit is set in both `stat_o` and `en_o`. It follows the registers with no extra cycle of delay.
- R8: `rx_irq_o` is high exactly when some status bit of the receive group (mask 0x0BB0: bits 4, 5, 7, 8, 9 and 11) is set and enabled.
- R9: `tx_irq_o` is high exactly when some status bit of the transmit group (mask 0x004C: bits 2, 3 and 6) is set and enabled. Bits 0, 1, 10, 12 and 13 belong to neither group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 14 | One-cycle event pulses, one per status bit |
| stat_wr_i | input | 1 | Write strobe for the status register (write-one-to-clear) |
| en_wr_i | input | 1 | Write strobe for the enable register |
| wdata_i | input | 14 | Write data shared by both registers |
| stat_o | output | 14 | Status register contents |
| en_o | output | 14 | Enable register contents |
| irq_o | output | 1 | Interrupt level, high while any enabled status bit is set |
| rx_irq_o | output | 1 | High while any enabled receive-group bit is set |
| tx_irq_o | output | 1 | High while any enabled transmit-group bit is set |

## Verification
Directed steps come first. They include a masked event on the highest bit, which shows that recording is separate from signalling. A clearing write with zero in the set bit's position tells write-one-to-clear apart from a plain load. An event arriving together with its own clear checks the priority rule. Enabled events in the receive group, the transmit group and in neither group separate the three interrupt outputs. A long run of sparse random events mixed with random clears and mask writes is then compared every cycle against a behavioural model. This catches wrong bit positions, a missing hold, or a lost event that a fixed pattern could miss.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int unsigned EVT_W = 14;

  typedef enum int unsigned {
    EV_TX_HOLD_EMPTY = 0,
    EV_RX_HOLD_FULL  = 1,
    EV_TXF_LOW       = 2,
    EV_TXF_EMPTY     = 3,
    EV_RXF_HIGH      = 4,
    EV_RXF_FULL      = 5,
    EV_TX_UNDERRUN   = 6,
    EV_RX_OVERRUN    = 7,
    EV_PARITY        = 8,
    EV_FRAMING       = 9,
    EV_CTS_CHANGE    = 10,
    EV_RX_IDLE       = 11,
    EV_BREAK_END     = 12,
    EV_BUS_ERR       = 13
  } evt_idx_e;

  // Group membership masks: receive side and transmit side
  localparam logic [EVT_W-1:0] RX_GROUP = 14'h0BB0;
  localparam logic [EVT_W-1:0] TX_GROUP = 14'h004C;
endpackage

// File: rtl/uirq_rst_sync.sv
module uirq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/uirq_status.sv
module uirq_status #(
  parameter int unsigned W = uirq_pkg::EVT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_mask_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;
  logic [W-1:0] stat_d;
  logic [W-1:0] bit_en;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      bit_en[i] = evt_i[i] | (clr_we_i & clr_mask_i[i]);
      // an arriving event outranks a clear of the same bit
      stat_d[i] = evt_i[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         stat_q[i] <= 1'b0;
      else if (bit_en[i]) stat_q[i] <= stat_d[i];
    end
  end

  assign stat_o = stat_q;

  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

  a_r3_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  a_r4_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i |=> ((stat_q & $past(clr_mask_i) & ~$past(evt_i)) == '0));

  a_r4_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i |=> ((stat_q & $past(stat_q) & ~$past(clr_mask_i))
                  == ($past(stat_q) & ~$past(clr_mask_i))));
endmodule

// File: rtl/uirq_mask.sv
module uirq_mask #(
  parameter int unsigned W = uirq_pkg::EVT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;
  logic [W-1:0] mask_d;

  always_comb begin
    mask_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= '0;
    else if (we_i) mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (mask_q == $past(wdata_i)));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(mask_q));
endmodule

// File: rtl/uirq_combine.sv
module uirq_combine #(
  parameter int unsigned   W      = uirq_pkg::EVT_W,
  parameter logic [W-1:0]  RX_SEL = uirq_pkg::RX_GROUP,
  parameter logic [W-1:0]  TX_SEL = uirq_pkg::TX_GROUP
) (
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o,
  output logic         rx_o,
  output logic         tx_o
);
  logic [W-1:0] live;

  always_comb begin
    live  = stat_i & mask_i;
    irq_o = |live;
    rx_o  = |(live & RX_SEL);
    tx_o  = |(live & TX_SEL);
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int unsigned W = uirq_pkg::EVT_W
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] evt_i,
  input  logic         stat_wr_i,
  input  logic         en_wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] en_o,
  output logic         irq_o,
  output logic         rx_irq_o,
  output logic         tx_irq_o
);
  logic rst_n;

  uirq_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  uirq_status #(.W(W)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_i),
    .clr_we_i   (stat_wr_i),
    .clr_mask_i (wdata_i),
    .stat_o     (stat_o)
  );

  uirq_mask #(.W(W)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (en_wr_i),
    .wdata_i (wdata_i),
    .mask_o  (en_o)
  );

  uirq_combine #(.W(W)) u_comb (
    .stat_i (stat_o),
    .mask_i (en_o),
    .irq_o  (irq_o),
    .rx_o   (rx_irq_o),
    .tx_o   (tx_irq_o)
  );

  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o == '0) |-> !irq_o);

  a_r8_rx_implies_irq: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq_o |-> irq_o);

  a_r9_tx_implies_irq: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq_o |-> irq_o);
endmodule

// File: tb/tb_uart_irq_ctrl.sv
module tb_uart_irq_ctrl;
  localparam int W = 14;
  localparam logic [W-1:0] RXM = 14'h0BB0;
  localparam logic [W-1:0] TXM = 14'h004C;

  logic clk = 1'b0;
  logic arst_n;
  logic [W-1:0] evt_i;
  logic stat_wr_i, en_wr_i;
  logic [W-1:0] wdata_i;
  logic [W-1:0] stat_o, en_o;
  logic irq_o, rx_irq_o, tx_irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_irq_ctrl dut (
    .clk(clk), .arst_n(arst_n), .evt_i(evt_i), .stat_wr_i(stat_wr_i),
    .en_wr_i(en_wr_i), .wdata_i(wdata_i), .stat_o(stat_o), .en_o(en_o),
    .irq_o(irq_o), .rx_irq_o(rx_irq_o), .tx_irq_o(tx_irq_o)
  );

  // behavioural reference
  logic [W-1:0] m_stat, m_en;
  int m_hold;

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      m_stat = '0; m_en = '0; m_hold = 0;
    end else if (m_hold < 2) begin
      m_hold = m_hold + 1;
    end else begin
      if (stat_wr_i) m_stat = m_stat & ~wdata_i;
      m_stat = m_stat | evt_i;
      if (en_wr_i) m_en = wdata_i;
    end
  end

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check("R2/R3/R4/R5 status vs model", stat_o, m_stat);
      check("R6 enable vs model", en_o, m_en);
      check("R7 irq vs model", {13'b0, irq_o}, {13'b0, |(m_stat & m_en)});
      check("R8 rx group vs model", {13'b0, rx_irq_o}, {13'b0, |(m_stat & m_en & RXM)});
      check("R9 tx group vs model", {13'b0, tx_irq_o}, {13'b0, |(m_stat & m_en & TXM)});
    end
  end

  task automatic step(logic [W-1:0] ev, logic sw, logic ew, logic [W-1:0] wd);
    @(negedge clk);
    evt_i = ev; stat_wr_i = sw; en_wr_i = ew; wdata_i = wd;
    @(negedge clk);
    evt_i = '0; stat_wr_i = 0; en_wr_i = 0; wdata_i = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    arst_n = 0; evt_i = '0; stat_wr_i = 0; en_wr_i = 0; wdata_i = '0;
    repeat (3) @(negedge clk);
    // R1: cleared under reset
    check("R1 status in reset", stat_o, '0);
    check("R1 enable in reset", en_o, '0);
    check("R1 irq in reset", {13'b0, irq_o}, '0);
    arst_n = 1;
    // R1: event applied across the two edges after release is ignored
    evt_i = 14'h3FFF; en_wr_i = 1; wdata_i = 14'h3FFF;
    @(negedge clk);
    @(negedge clk);
    check("R1 no capture during release", stat_o, '0);
    check("R1 no enable load during release", en_o, '0);
    evt_i = '0; en_wr_i = 0; wdata_i = '0;
    @(negedge clk);
    // R2: masked bus-error event recorded, no interrupt
    step(14'h2000, 0, 0, '0);
    check("R2 masked event recorded", stat_o, 14'h2000);
    check("R2 masked event no irq", {13'b0, irq_o}, '0);
    @(negedge clk);
    check("R3 sticky", stat_o, 14'h2000);
    step('0, 0, 1, 14'h2000);
    check("R6 enable loaded", en_o, 14'h2000);
    check("R7 irq on enable", {13'b0, irq_o}, 14'h1);
    check("R8 bit13 not rx", {13'b0, rx_irq_o}, '0);
    step('0, 1, 0, 14'h0001);
    check("R4 zero leaves bit", stat_o, 14'h2000);
    step('0, 1, 0, 14'h2000);
    check("R4 one clears bit", stat_o, '0);
    check("R7 irq drops", {13'b0, irq_o}, '0);
    step(14'h0020, 1, 0, 14'h0020);
    check("R5 event beats clear", stat_o, 14'h0020);
    step('0, 0, 1, 14'h0020);
    check("R8 rx group", {13'b0, rx_irq_o}, 14'h1);
    check("R9 tx quiet", {13'b0, tx_irq_o}, '0);
    step(14'h0008, 1, 0, 14'h0020);
    step('0, 0, 1, 14'h0008);
    check("R9 tx group", {13'b0, tx_irq_o}, 14'h1);
    check("R8 rx masked off", {13'b0, rx_irq_o}, '0);
    step(14'h0001, 0, 1, 14'h0001);
    check("R7 irq on ungrouped bit", {13'b0, irq_o}, 14'h1);
    check("R8 R9 ungrouped bit", {12'b0, rx_irq_o, tx_irq_o}, '0);
    // random run against model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      evt_i     = W'($urandom) & W'($urandom) & W'($urandom);
      stat_wr_i = ($urandom % 4) == 0;
      en_wr_i   = ($urandom % 16) == 0;
      wdata_i   = W'($urandom);
    end
    @(negedge clk);
    evt_i = '0; stat_wr_i = 0; en_wr_i = 0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule